// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Write Port

This block is the device end of a byte-wide configuration port that an external host drives as an asynchronous peripheral. Everything runs on a configuration clock supplied from outside. The host places a byte on an 8-bit bus and asserts an active-low write strobe together with two active-low chip selects. The port captures the byte on a rising clock edge and presents it to a downstream configuration sink through a valid/ready pair. It then raises BUSY to hold the host off while the byte is processed and handed on.

The host can pause a transfer at any time by raising either chip select. While a select is high the port takes no byte and keeps all of its state. Transfers resume once both selects are low again. After a fixed number of bytes have been delivered, the port raises DONE and ignores further writes. An active-low program input resets the port. After program is released, the port holds its init output low for a set number of cycles and only then accepts writes.

Top module: `cfgp_port`

## Requirements
- R1: A byte is captured at a rising `cfg_clk` edge only when `wr_n`, `sel_a_n` and `sel_b_n` are all low at that edge while `busy` is low, `init_n` is high and `done` is low. After that edge `busy` and `sink_valid` are high and `sink_data` equals the captured byte. In every other case `busy` stays low.
- R2: When `sink_ready` is high from the capture onward and the byte is not the last one, `busy` stays high for exactly PROC_CYCLES clock cycles after the capture edge.
- R3: While `sink_valid` is high and `sink_ready` is low, `sink_valid` and `sink_data` hold steady and `busy` stays high. Counting edges from the capture, `busy` falls at edge max(PROC_CYCLES, h), where h is the edge at which the sink accepts the byte.
- R4: While either select is high, a low write strobe captures nothing: `busy` and `sink_valid` stay low and the byte count does not change.
- R5: After a suspension, the write is taken at the first edge at which both selects are low again.
- R6: `done` rises at the edge at which the sink accepts byte number TOTAL_BYTES. At that same edge `busy` and `sink_valid` go low.
- R7: While `done` is high it stays high, and write strobes are ignored: `busy` and `sink_valid` stay low.
- R8: While `prog_n` is low, `busy`, `done` and `sink_valid` are low and `init_n` is low. After `prog_n` rises, `init_n` stays low for exactly INIT_CYCLES clock edges and then goes high. Writes attempted during that time are ignored. The byte count restarts from zero.
- R9: Bytes reach the sink in the order the host wrote them, each one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock supplied by the host side |
| prog_n | input | 1 | Active-low program; asynchronous clear of the port |
| wr_n | input | 1 | Active-low write strobe |
| sel_a_n | input | 1 | First active-low chip select |
| sel_b_n | input | 1 | Second active-low chip select |
| host_data | input | DATA_W | Host data bus (8 bits by default) |
| busy | output | 1 | High while a byte is being processed or handed on |
| init_n | output | 1 | Low during reset and the initialisation interval |
| done | output | 1 | High once all bytes have been delivered |
| sink_data | output | DATA_W | Byte offered to the configuration sink |
| sink_valid | output | 1 | Offered byte is valid |
| sink_ready | input | 1 | Sink accepts the offered byte |

## Verification
The assertions check the rules that hold on every cycle. A qualified write always starts BUSY with the byte on the sink bus. A raised select never starts a capture. A stalled sink keeps the byte and BUSY steady. DONE stays set and quiet. Nothing moves while init is low. The exact length of BUSY, the exact init interval, the ordering of bytes and the point at which DONE rises all depend on counting across many cycles, so only the bench's scenarios can show them. Those scenarios mix random sink delays, suspensions and strobes held low through BUSY.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_PROC = 2'd2,
        ST_DONE = 2'd3
    } cfgp_state_e;

    typedef struct packed {
        cfgp_state_e state;
    } cfgp_fsm_t;

endpackage

// File: rtl/cfgp_wr_qual.sv
module cfgp_wr_qual (
    input  logic wr_n,
    input  logic sel_a_n,
    input  logic sel_b_n,
    output logic take,
    output logic held
);
    logic strobe;
    logic selected;

    always_comb begin
        strobe   = ~wr_n;
        selected = ~sel_a_n & ~sel_b_n;
        take     = strobe & selected;
        held     = strobe & ~selected;
    end
endmodule

// File: rtl/cfgp_tick_cnt.sv
module cfgp_tick_cnt #(
    parameter int CNT_W   = 2,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.cnt = load_val;
        end else if (dec && (cur_q.cnt != '0)) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
        zero = (cur_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt <= RST_CNT;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/cfgp_hold_reg.sv
module cfgp_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              accept
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        accept = cur_q.valid & ready;
        if (capture) begin
            nxt_d.valid = 1'b1;
            nxt_d.data  = din;
        end else if (accept) begin
            nxt_d.valid = 1'b0;
        end
        valid = cur_q.valid;
        data  = cur_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.valid && !ready) |=> (cur_q.valid && $stable(cur_q.data))); // R3
endmodule

// File: rtl/cfgp_byte_cnt.sv
module cfgp_byte_cnt #(
    parameter int TOTAL_BYTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = (TOTAL_BYTES > 1) ? $clog2(TOTAL_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_BYTES - 1);

    generate
        if (TOTAL_BYTES == 1) begin : g_single
            always_comb last = 1'b1;
        end else begin : g_count
            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } bc_t;

            bc_t cur_q, nxt_d;

            always_comb begin
                nxt_d = cur_q;
                if (inc && (cur_q.cnt != LAST_IDX)) begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
                last = (cur_q.cnt == LAST_IDX);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur_q <= '0;
                end else begin
                    cur_q <= nxt_d;
                end
            end

            AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                (last && !inc) |=> last); // R6
        end
    endgenerate
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port #(
    parameter int DATA_W      = 8,
    parameter int PROC_CYCLES = 2,
    parameter int INIT_CYCLES = 4,
    parameter int TOTAL_BYTES = 16
) (
    input  logic              cfg_clk,
    input  logic              prog_n,
    input  logic              wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic [DATA_W-1:0] host_data,
    output logic              busy,
    output logic              init_n,
    output logic              done,
    output logic [DATA_W-1:0] sink_data,
    output logic              sink_valid,
    input  logic              sink_ready
);
    import cfgp_pkg::*;

    localparam int PROC_W = $clog2(PROC_CYCLES + 1);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [PROC_W-1:0] PROC_LOAD = PROC_W'(PROC_CYCLES - 1);
    localparam logic [INIT_W-1:0] INIT_LOAD = INIT_W'(INIT_CYCLES - 1);

    cfgp_fsm_t fsm_q, fsm_d;

    logic take;
    logic held;
    logic init_zero;
    logic init_dec;
    logic proc_zero;
    logic proc_load;
    logic proc_dec;
    logic capture;
    logic accept;
    logic last_byte;

    cfgp_wr_qual u_qual (
        .wr_n    (wr_n),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .take    (take),
        .held    (held)
    );

    cfgp_tick_cnt #(
        .CNT_W   (INIT_W),
        .RST_VAL (INIT_CYCLES - 1)
    ) u_init_cnt (
        .clk      (cfg_clk),
        .rst_n    (prog_n),
        .load     (1'b0),
        .load_val (INIT_LOAD),
        .dec      (init_dec),
        .zero     (init_zero)
    );

    cfgp_tick_cnt #(
        .CNT_W   (PROC_W),
        .RST_VAL (0)
    ) u_proc_cnt (
        .clk      (cfg_clk),
        .rst_n    (prog_n),
        .load     (proc_load),
        .load_val (PROC_LOAD),
        .dec      (proc_dec),
        .zero     (proc_zero)
    );

    cfgp_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (cfg_clk),
        .rst_n   (prog_n),
        .capture (capture),
        .din     (host_data),
        .ready   (sink_ready),
        .valid   (sink_valid),
        .data    (sink_data),
        .accept  (accept)
    );

    cfgp_byte_cnt #(
        .TOTAL_BYTES (TOTAL_BYTES)
    ) u_bytes (
        .clk   (cfg_clk),
        .rst_n (prog_n),
        .inc   (accept),
        .last  (last_byte)
    );

    always_comb begin
        fsm_d     = fsm_q;
        init_dec  = 1'b0;
        proc_load = 1'b0;
        proc_dec  = 1'b0;
        capture   = 1'b0;
        unique case (fsm_q.state)
            ST_INIT: begin
                if (init_zero) begin
                    fsm_d.state = ST_IDLE;
                end else begin
                    init_dec = 1'b1;
                end
            end
            ST_IDLE: begin
                if (take) begin
                    capture     = 1'b1;
                    proc_load   = 1'b1;
                    fsm_d.state = ST_PROC;
                end
            end
            ST_PROC: begin
                proc_dec = ~proc_zero;
                if (accept && last_byte) begin
                    fsm_d.state = ST_DONE;
                end else if (proc_zero && (!sink_valid || accept)) begin
                    fsm_d.state = ST_IDLE;
                end
            end
            ST_DONE: begin
                fsm_d.state = ST_DONE;
            end
            default: begin
                fsm_d.state = ST_INIT;
            end
        endcase
    end

    always_ff @(posedge cfg_clk or negedge prog_n) begin
        if (!prog_n) begin
            fsm_q.state <= ST_INIT;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        busy   = (fsm_q.state == ST_PROC);
        init_n = (fsm_q.state != ST_INIT);
        done   = (fsm_q.state == ST_DONE);
    end

    AST_TAKE_STARTS_BUSY: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (!busy && init_n && !done && !wr_n && !sel_a_n && !sel_b_n)
        |=> (busy && sink_valid && (sink_data == $past(host_data)))); // R1

    AST_SUSPEND_HOLDS: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (!busy && held) |=> (!busy && !sink_valid)); // R4

    AST_BUSY_MIN: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (busy && !proc_zero) |=> (busy || done)); // R2

    AST_STALL_KEEPS_BUSY: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (sink_valid && !sink_ready) |=> busy); // R3

    AST_DONE_QUIET: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |-> (!busy && !sink_valid)); // R7

    AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |=> done); // R7

    AST_INIT_BLOCKS: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        !init_n |-> (!busy && !done && !sink_valid)); // R8
endmodule

// File: tb/cfgp_port_tb_top.sv
`timescale 1ns/1ps
module cfgp_port_tb_top;
    localparam int DW    = 8;
    localparam int PROC  = 2;
    localparam int INIT  = 4;
    localparam int TOTAL = 16;

    logic          cfg_clk = 1'b0;
    logic          prog_n;
    logic          wr_n;
    logic          sel_a_n;
    logic          sel_b_n;
    logic [DW-1:0] host_data;
    logic          busy;
    logic          init_n;
    logic          done;
    logic [DW-1:0] sink_data;
    logic          sink_valid;
    logic          sink_ready;

    int nchk  = 0;
    int nerr  = 0;
    int nbyte = 0;
    bit finished = 1'b0;

    always #2.5 cfg_clk = ~cfg_clk;

    cfgp_port #(
        .DATA_W      (DW),
        .PROC_CYCLES (PROC),
        .INIT_CYCLES (INIT),
        .TOTAL_BYTES (TOTAL)
    ) dut_i (
        .cfg_clk    (cfg_clk),
        .prog_n     (prog_n),
        .wr_n       (wr_n),
        .sel_a_n    (sel_a_n),
        .sel_b_n    (sel_b_n),
        .host_data  (host_data),
        .busy       (busy),
        .init_n     (init_n),
        .done       (done),
        .sink_data  (sink_data),
        .sink_valid (sink_valid),
        .sink_ready (sink_ready)
    );

    function automatic int busy_len(input int rdly, input bit fin);
        int h;
        h = rdly + 1;
        if (fin) return h;
        return (h > PROC) ? h : PROC;
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step;
        @(posedge cfg_clk);
        #1;
    endtask

    // One host write: optional suspension, optional strobe held through busy
    task automatic write_one(input logic [DW-1:0] b, input int rdly, input int susp,
                             input bit use_b, input bit hammer);
        int  h;
        int  k;
        bit  fin;
        if (susp > 0) begin
            wr_n      = 1'b0;
            host_data = b;
            sel_a_n   = ~use_b;
            sel_b_n   = use_b;
            for (int i = 0; i < susp; i++) begin
                step();
                chk("R4 busy while suspended", busy, 0);
                chk("R4 valid while suspended", sink_valid, 0);
            end
        end
        sel_a_n   = 1'b0;
        sel_b_n   = 1'b0;
        wr_n      = 1'b0;
        host_data = b;
        step();
        nbyte++;
        fin = (nbyte == TOTAL);
        chk(susp > 0 ? "R5 resumed capture busy" : "R1 capture busy", busy, 1);
        chk("R1 capture valid", sink_valid, 1);
        chk("R1 capture data", sink_data, b);
        wr_n      = hammer ? 1'b0 : 1'b1;
        host_data = DW'($urandom);
        h = rdly + 1;
        k = busy_len(rdly, fin);
        sink_ready = (rdly == 0);
        for (int j = 1; j <= k; j++) begin
            step();
            chk("R3 valid", sink_valid, (j < h) ? 1 : 0);
            if (j < h) chk("R9 held data", sink_data, b);
            chk((rdly == 0 && !fin) ? "R2 busy length" : "R3 busy length",
                busy, (j < k) ? 1 : 0);
            if (fin) chk("R6 done at final accept", done, (j >= h) ? 1 : 0);
            else     chk("R6 done early", done, 0);
            if (hammer) host_data = DW'($urandom);
            if (j == rdly) sink_ready = 1'b1;
            if (j >= h)    sink_ready = 1'b0;
        end
        wr_n       = 1'b1;
        sink_ready = 1'b0;
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            wr_n    = 1'b1;
            sel_a_n = 1'($urandom);
            sel_b_n = 1'($urandom);
            step();
            chk("R1 no strobe no capture", busy, 0);
        end
    endtask

    task automatic program_and_init;
        prog_n = 1'b0;
        step();
        step();
        chk("R8 busy in program", busy, 0);
        chk("R8 init_n in program", init_n, 0);
        chk("R8 done in program", done, 0);
        chk("R8 valid in program", sink_valid, 0);
        prog_n    = 1'b1;
        wr_n      = 1'b0;
        sel_a_n   = 1'b0;
        sel_b_n   = 1'b0;
        host_data = 8'h5A;
        for (int j = 1; j <= INIT; j++) begin
            step();
            chk("R8 init interval", init_n, (j >= INIT) ? 1 : 0);
            chk("R8 write during init", busy, 0);
        end
        wr_n  = 1'b1;
        nbyte = 0;
    endtask

    task automatic session;
        program_and_init();
        write_one(8'hA5, 0, 0, 1'b0, 1'b0);
        idle_gap(1);
        write_one(8'h3C, 3, 0, 1'b0, 1'b0);
        write_one(8'h00, 0, 2, 1'b0, 1'b0);
        idle_gap(2);
        write_one(8'hFF, 1, 3, 1'b1, 1'b1);
        while (nbyte < TOTAL - 1) begin
            idle_gap($urandom_range(0, 2));
            write_one(DW'($urandom), $urandom_range(0, 3), $urandom_range(0, 2),
                      1'($urandom), 1'($urandom));
        end
        write_one(8'hC3, 2, 1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            wr_n      = 1'b0;
            sel_a_n   = 1'b0;
            sel_b_n   = 1'b0;
            host_data = DW'($urandom);
            step();
            chk("R7 busy after done", busy, 0);
            chk("R7 valid after done", sink_valid, 0);
            chk("R7 done sticky", done, 1);
        end
        wr_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        prog_n     = 1'b0;
        wr_n       = 1'b1;
        sel_a_n    = 1'b1;
        sel_b_n    = 1'b1;
        host_data  = '0;
        sink_ready = 1'b0;
        session();
        session();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge cfg_clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule